// File: doc/BRIEF.md
# Channel and Type Selecting Pixel Regrouper

This block sits on a stream of already unpacked pixels. Each input beat carries one pixel and is tagged with its packet's 6-bit data type and 4-bit virtual channel. A beat with the frame-start flag set is a marker and carries no pixel. The block keeps only the pixels whose channel equals the run-time channel setting and whose type is the main type, RAW8 (0x2A) or one of the user byte types (0x30 to 0x37). It collects the kept pixels into output beats of `PPC` pixels each, where `PPC` is 1, 2 or 4.

The output port is sized for the widest pixel. The slot width is the larger of 8 and `MAIN_W`. The data width is `PPC` slots rounded up to a whole byte. An 8-bit pixel travelling on a wider slot sits at the top of its slot. The output has no byte-enable. A line whose length is not a multiple of `PPC` ends with a short beat: its unused slots are zero and `out_last` is set.

A two-bit user field marks frame start (bit 0) and carries the packet error flag (bit 1). The destination field repeats the packet's type and channel. Output back-pressure stalls the input without losing or repeating pixels. Packets are assumed contiguous on the input: beats of two packets are never interleaved.

Top module: `vcdt_filter_bridge`

## Requirements
- R1: An input beat whose `in_vc` differs from `cfg_vc`, or whose `in_dt` is neither `MAIN_DT`, 0x2A nor in 0x30..0x37, is accepted and never appears on the output.
- R2: Types 0x2A and 0x30..0x37 are forwarded in addition to `MAIN_DT`, whatever `MAIN_DT` is. Their 8-bit pixel is taken from `in_pixel[7:0]`.
- R3: `out_dest[9:4]` is the packet's data type and `out_dest[3:0]` its virtual channel.
- R4: The output data width is `ceil(max(8,MAIN_W)*PPC/8)*8`. With the defaults (`MAIN_W`=10, `PPC`=2) this is 24 bits.
- R5: The k-th pixel of a beat occupies bits `[k*SW +: SW]`, with the first pixel at the lowest slot. A pixel narrower than `SW` is justified to the top of its slot. Bits above `PPC*SW` are zero.
- R6: A full output beat is emitted once `PPC` kept pixels of one packet have been collected.
- R7: The beat holding a packet's final pixel has `out_last`=1. If that beat is short, its unfilled slots are zero. All other beats have `out_last`=0.
- R8: A frame-start beat on `cfg_vc` produces no output. It sets `out_user[0]` on the first output beat of the next kept packet only. A frame start on another channel has no effect.
- R9: `out_user[1]` is the OR of `in_err` over the pixels contained in that beat.
- R10: While `out_valid`=1 and `out_ready`=0, every output stays unchanged and `in_ready`=0. Every kept pixel appears exactly once, in order.
- R11: During and straight after reset `out_valid`=0, and after reset `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vc | input | 4 | Virtual channel to keep |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_pixel | input | SW | One pixel, right-aligned |
| in_dt | input | 6 | Data type of the packet |
| in_vc | input | 4 | Virtual channel of the packet |
| in_fs | input | 1 | Frame-start marker beat (no pixel) |
| in_last | input | 1 | Last pixel of the packet (line) |
| in_err | input | 1 | Packet error flag for this pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | OUT_W | Packed pixel slots |
| out_last | output | 1 | End of line |
| out_user | output | 2 | Bit 0 frame start, bit 1 packet error |
| out_dest | output | 10 | Data type [9:4], virtual channel [3:0] |

## Verification
The assertions check four things on every cycle:
- the output stays frozen and the input stays blocked during a stall;
- no filtered or frame-start beat raises the output valid;
- the destination channel and type always belong to the accepted set;
- the padding bits stay zero.

Only the bench's reference model can show the rest:
- the exact slot position and justification of each pixel;
- zero-filling of short final beats;
- which single beat carries frame start;
- the error OR over a group;
- that no pixel is lost or repeated under random back-pressure.

// File: rtl/vcdt_pkg.sv
package vcdt_pkg;

    localparam logic [5:0] DT_BYTE_RAW8 = 6'h2A;
    localparam logic [5:0] DT_USER_LO   = 6'h30;
    localparam logic [5:0] DT_USER_HI   = 6'h37;

    typedef enum logic [1:0] {
        PK_EMPTY = 2'd0,
        PK_FILL  = 2'd1,
        PK_HOLD  = 2'd2
    } pk_state_e;

    function automatic logic is_byte_dt(input logic [5:0] dt);
        return (dt == DT_BYTE_RAW8) || ((dt >= DT_USER_LO) && (dt <= DT_USER_HI));
    endfunction

endpackage

// File: rtl/vcdt_match.sv
module vcdt_match #(
    parameter logic [5:0] MAIN_DT = 6'h2B
) (
    input  logic [5:0] in_dt,
    input  logic [3:0] in_vc,
    input  logic       in_fs,
    input  logic [3:0] cfg_vc,
    output logic       keep,
    output logic       is_main,
    output logic       fs_hit
);
    import vcdt_pkg::*;

    logic vc_ok;

    always_comb begin
        vc_ok   = (in_vc == cfg_vc);
        is_main = (in_dt == MAIN_DT);
        // frame-start markers never carry a pixel
        keep    = !in_fs && vc_ok && (is_main || is_byte_dt(in_dt));
        fs_hit  = in_fs && vc_ok;
    end

endmodule

// File: rtl/slot_fmt.sv
module slot_fmt #(
    parameter int MAIN_W = 10,
    parameter int SW     = 10
) (
    input  logic [SW-1:0] pixel,
    input  logic          is_main,
    output logic [SW-1:0] slot
);
    localparam int MAIN_SH = SW - MAIN_W;
    localparam int BYTE_SH = SW - 8;

    logic [SW-1:0] main_slot;
    logic [SW-1:0] byte_slot;

    always_comb begin
        main_slot = SW'(pixel[MAIN_W-1:0]) << MAIN_SH;
        byte_slot = SW'(pixel[7:0]) << BYTE_SH;
        slot      = is_main ? main_slot : byte_slot;
    end

endmodule

// File: rtl/beat_packer.sv
module beat_packer #(
    parameter int PPC   = 2,
    parameter int SW    = 10,
    parameter int OUT_W = 24,
    localparam int IW   = (PPC > 1) ? $clog2(PPC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             pix_keep,
    input  logic [SW-1:0]    pix_slot,
    input  logic             fs_hit,
    input  logic [5:0]       in_dt,
    input  logic [3:0]       in_vc,
    input  logic             in_last,
    input  logic             in_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic [1:0]       out_user,
    output logic [9:0]       out_dest
);
    import vcdt_pkg::*;

    pk_state_e     state_q, state_d;
    logic [IW-1:0] cnt_q;
    logic [SW-1:0] slots_q [PPC];
    logic          last_q, err_q, sof_q, pend_q;
    logic [9:0]    dest_q;

    logic          hold, fire, pix_take, fresh, group_done;
    logic [IW-1:0] idx;

    always_comb begin
        hold       = (state_q == PK_HOLD);
        in_ready   = !hold || out_ready;
        fire       = in_valid && in_ready;
        pix_take   = fire && pix_keep;
        fresh      = (state_q != PK_FILL);
        idx        = fresh ? '0 : cnt_q;
        group_done = pix_take && ((32'(idx) == PPC - 1) || in_last);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_EMPTY: if (pix_take) state_d = group_done ? PK_HOLD : PK_FILL;
            PK_FILL:  if (group_done) state_d = PK_HOLD;
            PK_HOLD: begin
                if (out_ready) begin
                    if (pix_take) state_d = group_done ? PK_HOLD : PK_FILL;
                    else          state_d = PK_EMPTY;
                end
            end
            default:  state_d = PK_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PK_EMPTY;
        else        state_q <= state_d;
    end

    // group datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
            err_q  <= 1'b0;
            sof_q  <= 1'b0;
            pend_q <= 1'b0;
            dest_q <= '0;
            for (int k = 0; k < PPC; k++) slots_q[k] <= '0;
        end else begin
            if (fire && fs_hit) pend_q <= 1'b1;
            if (pix_take) begin
                for (int k = 0; k < PPC; k++) begin
                    if (k == 32'(idx))  slots_q[k] <= pix_slot;
                    else if (fresh)     slots_q[k] <= '0;
                end
                if (fresh) begin
                    err_q  <= in_err;
                    sof_q  <= pend_q;
                    pend_q <= 1'b0;
                    dest_q <= {in_dt, in_vc};
                end else begin
                    err_q  <= err_q | in_err;
                end
                last_q <= in_last;
                cnt_q  <= group_done ? '0 : IW'(32'(idx) + 1);
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = hold;
        out_last  = last_q;
        out_user  = {err_q, sof_q};
        out_dest  = dest_q;
        out_data  = '0;
        for (int k = 0; k < PPC; k++) out_data[k*SW +: SW] = slots_q[k];
    end

endmodule

// File: rtl/vcdt_filter_bridge.sv
module vcdt_filter_bridge #(
    parameter logic [5:0] MAIN_DT = 6'h2B,
    parameter int MAIN_W  = 10,
    parameter int PPC     = 2,
    localparam int SW     = (MAIN_W > 8) ? MAIN_W : 8,
    localparam int OUT_W  = ((SW * PPC + 7) / 8) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_vc,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SW-1:0]    in_pixel,
    input  logic [5:0]       in_dt,
    input  logic [3:0]       in_vc,
    input  logic             in_fs,
    input  logic             in_last,
    input  logic             in_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic [1:0]       out_user,
    output logic [9:0]       out_dest
);
    logic          pix_keep, pix_main, fs_hit;
    logic [SW-1:0] pix_slot;

    vcdt_match #(.MAIN_DT(MAIN_DT)) u_match (
        .in_dt   (in_dt),
        .in_vc   (in_vc),
        .in_fs   (in_fs),
        .cfg_vc  (cfg_vc),
        .keep    (pix_keep),
        .is_main (pix_main),
        .fs_hit  (fs_hit)
    );

    slot_fmt #(.MAIN_W(MAIN_W), .SW(SW)) u_fmt (
        .pixel   (in_pixel),
        .is_main (pix_main),
        .slot    (pix_slot)
    );

    beat_packer #(.PPC(PPC), .SW(SW), .OUT_W(OUT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .pix_keep  (pix_keep),
        .pix_slot  (pix_slot),
        .fs_hit    (fs_hit),
        .in_dt     (in_dt),
        .in_vc     (in_vc),
        .in_last   (in_last),
        .in_err    (in_err),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_user  (out_user),
        .out_dest  (out_dest)
    );

endmodule

// File: rtl/vcdt_filter_bridge_chk.sv
module vcdt_filter_bridge_chk #(
    parameter logic [5:0] MAIN_DT = 6'h2B,
    parameter int SW    = 10,
    parameter int PPC   = 2,
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cfg_vc,
    input logic             in_valid,
    input logic             in_ready,
    input logic [5:0]       in_dt,
    input logic [3:0]       in_vc,
    input logic             in_fs,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_last,
    input logic [1:0]       out_user,
    input logic [9:0]       out_dest
);
    import vcdt_pkg::*;

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)
                                       && $stable(out_user) && $stable(out_dest)));

    assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_drop_vc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !out_valid && (in_vc != cfg_vc)) |=> !out_valid);

    assert_fs_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !out_valid && in_fs) |=> !out_valid);

    assert_dest_vc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dest[3:0] == cfg_vc));

    assert_dest_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_dest[9:4] == MAIN_DT) || is_byte_dt(out_dest[9:4])));

    generate
        if (OUT_W > PPC * SW) begin : g_pad
            assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_data[OUT_W-1:PPC*SW] == '0));
        end
    endgenerate

endmodule

bind vcdt_filter_bridge vcdt_filter_bridge_chk #(
    .MAIN_DT(MAIN_DT), .SW(SW), .PPC(PPC), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_vc(cfg_vc), .in_valid(in_valid), .in_ready(in_ready),
    .in_dt(in_dt), .in_vc(in_vc), .in_fs(in_fs), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_user(out_user), .out_dest(out_dest)
);

// File: tb/vcdt_filter_bridge_test.sv
module vcdt_filter_bridge_test;

    localparam logic [3:0] CFG = 4'h5;
    localparam logic [5:0] MDT = 6'h2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_fs = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [9:0]  in_pixel = '0;
    logic [5:0]  in_dt = '0;
    logic [3:0]  in_vc = '0;
    logic        in_ready, out_valid, out_last;
    logic        out_ready = 1'b1;
    logic [23:0] out_data;
    logic [1:0]  out_user;
    logic [9:0]  out_dest;
    bit          bp_en = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [36:0] expq [$];

    always #10 clk = ~clk;

    vcdt_filter_bridge #(.MAIN_DT(MDT), .MAIN_W(10), .PPC(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_vc(CFG), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_dt(in_dt), .in_vc(in_vc), .in_fs(in_fs), .in_last(in_last),
        .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_user(out_user), .out_dest(out_dest)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // behavioural reference model, driven by the order of accepted beats
    int          m_cnt = 0;
    logic [23:0] m_data = '0;
    logic        m_err = 0, m_sof = 0, m_pend = 0;
    logic [9:0]  m_dest = '0;

    task automatic model(input logic [5:0] dt, input logic [3:0] vc, input logic [9:0] pix,
                         input logic last, input logic err, input logic fs);
        int w;
        logic [23:0] sv;
        if (fs) begin
            if (vc == CFG) m_pend = 1;
            return;
        end
        if (vc != CFG) return;
        if (!(dt == MDT || dt == 6'h2A || (dt >= 6'h30 && dt <= 6'h37))) return;
        w  = (dt == MDT) ? 10 : 8;
        sv = 24'((pix & ((10'd1 << w) - 10'd1)) << (10 - w));
        if (m_cnt == 0) begin
            m_data = '0; m_err = 0; m_sof = m_pend; m_pend = 0; m_dest = {dt, vc};
        end
        m_data = m_data | (sv << (m_cnt * 10));
        m_err  = m_err | err;
        m_cnt++;
        if (m_cnt == 2 || last) begin
            expq.push_back({m_data, last, m_err, m_sof, m_dest});
            m_cnt = 0;
        end
    endtask

    task automatic send(input logic [5:0] dt, input logic [3:0] vc, input logic [9:0] pix,
                        input logic last, input logic err, input logic fs);
        bit acc;
        model(dt, vc, pix, last, err, fs);
        @(negedge clk);
        in_valid = 1; in_dt = dt; in_vc = vc; in_pixel = pix;
        in_last = last; in_err = err; in_fs = fs;
        forever begin
            #9 acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 0; in_fs = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pkt(input logic [5:0] dt, input logic [3:0] vc, input int n,
                       input int seed, input int errpos);
        for (int i = 0; i < n; i++)
            send(dt, vc, 10'((seed * 53 + i * 97) ^ 10'h2C5), i == n - 1, i == errpos, 0);
    endtask

    task automatic drain(input string req);
        idle(1);
        for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, req, "expected beats left unsent", 64'(expq.size()), 0);
    endtask

    always @(negedge clk) out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;

    // output monitor, samples shortly before each rising edge
    logic        pv = 0, pr = 0;
    logic [36:0] pbus = '0;
    always @(negedge clk) begin
        logic [36:0] e, a;
        #9;
        a = {out_data, out_last, out_user, out_dest};
        if (rst_n) begin
            if (pv && !pr)
                chk(out_valid && a == pbus, "R10", "stalled beat changed", 64'(a), 64'(pbus));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R1", "unexpected output beat", 64'(a), 0);
                end else begin
                    e = expq.pop_front();
                    chk(a[36:13] == e[36:13], "R4 R5", "data", 64'(a[36:13]), 64'(e[36:13]));
                    chk(a[12] == e[12], "R7", "last", 64'(a[12]), 64'(e[12]));
                    chk(a[10] == e[10], "R8", "frame start", 64'(a[10]), 64'(e[10]));
                    chk(a[11] == e[11], "R9", "error", 64'(a[11]), 64'(e[11]));
                    chk(a[9:0] == e[9:0], "R3", "dest", 64'(a[9:0]), 64'(e[9:0]));
                end
            end
        end
        pv = out_valid && rst_n; pr = out_ready; pbus = a;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R11", "valid during reset", 64'(out_valid), 0);
        @(negedge clk); rst_n = 1;
        #9;
        chk(out_valid == 0, "R11", "valid after reset", 64'(out_valid), 0);
        chk(in_ready == 1, "R11", "ready after reset", 64'(in_ready), 1);

        // R6 R7 R8: frame start then odd-length main-type line, short final beat
        send(0, CFG, 0, 0, 0, 1);
        pkt(MDT, CFG, 5, 1, -1);
        pkt(MDT, CFG, 4, 2, -1);
        drain("R6 R7");

        // R1 R8: wrong channel, wrong type, foreign frame start all vanish
        send(0, 4'h3, 0, 0, 0, 1);
        pkt(MDT, 4'h3, 3, 3, -1);
        pkt(6'h2C, CFG, 3, 4, -1);
        pkt(6'h38, CFG, 2, 5, -1);
        pkt(6'h2F, CFG, 2, 6, -1);
        pkt(MDT, CFG, 2, 7, -1);
        drain("R1");

        // R2 R5 R9: byte types justified to slot top, error OR per beat
        pkt(6'h2A, CFG, 4, 8, 1);
        pkt(6'h30, CFG, 3, 9, 2);
        pkt(6'h37, CFG, 1, 10, -1);
        send(0, CFG, 0, 0, 0, 1);
        pkt(6'h35, CFG, 3, 11, 0);
        drain("R2 R9");

        // R10: random mix under random back-pressure and input gaps
        bp_en = 1;
        for (int p = 0; p < 60; p++) begin
            logic [5:0] dt;
            logic [3:0] vc;
            int sel = $urandom % 6;
            dt = (sel == 0) ? 6'h2A : (sel == 1) ? 6'h33 : (sel == 2) ? 6'h2C : MDT;
            vc = ($urandom % 4 == 0) ? 4'h2 : CFG;
            if ($urandom % 5 == 0) send(0, CFG, 0, 0, 0, 1);
            pkt(dt, vc, 1 + $urandom % 9, 20 + p, ($urandom % 3 == 0) ? int'($urandom % 9) : -1);
            if ($urandom % 3 == 0) idle($urandom % 3);
        end
        drain("R10");
        bp_en = 0;

        summary();
        $finish;
    end

endmodule